// File: doc/BRIEF.md
# Flash Program and Erase Sequencer

This block sits between a processor and a word-wide, command-driven parallel flash device. The processor gives it one request at a time: write a word, wipe one sector, wipe the whole device, or fetch the identification words. The block then produces every bus cycle the device needs. That means a fixed unlock preamble, the command byte, and the payload write, with write-enable pulse widths, setup and hold counted in clock cycles.

For program and erase requests it then waits for the device's internal operation to finish. It reads one address repeatedly and watches bit 6, which the device flips on every read while it is busy. The first read whose bit 6 matches the previous read marks completion. Program and erase each have their own wait limit. When a limit runs out, the block writes a reset command and reports an error.

An identification request enters the device's ID mode, reads three words, and leaves the mode again. The results are presented on dedicated outputs.

Top module: `flseq_top`

## Requirements
- R1: `req_ready` is high only while the block is idle. A request is taken when `req_valid` and `req_ready` are both high at a clock edge. `req_ready` is low in the cycle after acceptance, and high again in the cycle after `done_valid`.
- R2: A program request (`req_op`=0) issues four writes, as address/data pairs: 0x5555/0x00AA, 0x2AAA/0x0055, 0x5555/0x00A0, then `req_addr`/`req_data`.
- R3: A sector erase (`req_op`=1) issues six writes: 0x5555/0xAA, 0x2AAA/0x55, 0x5555/0x80, 0x5555/0xAA, 0x2AAA/0x55, then `req_addr`/0x30.
- R4: A chip erase (`req_op`=2) issues the same first five writes as R3, and its sixth write is 0x5555/0x10.
- R5: Write-enable stays low for at least `T_WP` cycles and high for at least `T_WPH` cycles between pulses. Address and write data do not change while write-enable is low.
- R6: Output-enable is never low while write-enable is low. Write-enable is low only while chip-enable is low.
- R7: After the command writes of a program or erase, every poll read uses `req_addr`. Output-enable stays high for at least `T_OEH` cycles between reads. The operation ends at the first read whose bit 6 equals bit 6 of the read before it, so at least two reads are made.
- R8: While polling, a limit of `PROG_TO` cycles applies to program and `ERASE_TO` cycles to both erases. When a non-settled read completes after the limit is reached, the block writes 0x5555/0xF0 and finishes with `done_err`=1. A settled finish gives `done_err`=0.
- R9: An ID request (`req_op`=3) writes 0x5555/0xAA, 0x2AAA/0x55, 0x5555/0x90. It then reads addresses 0, 1 and 2, and writes 0x5555/0xF0. `id_mfr` shows the low byte of read 0, `id_dev` the low byte of read 1, and `id_lock` bit 0 of read 2, all valid from `done_valid` on.
- R10: `done_valid` is a single-cycle pulse per accepted request.
- R11: Out of reset, chip-enable, output-enable and write-enable are high, `req_ready` is high and `done_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle and able to take a request |
| req_op | input | 2 | 0 program, 1 sector erase, 2 chip erase, 3 read ID |
| req_addr | input | AW | Target word address or sector address |
| req_data | input | DW | Word to program |
| done_valid | output | 1 | One-cycle completion pulse |
| done_err | output | 1 | Completion was a timeout |
| id_mfr | output | 8 | Manufacturer code from the last ID request |
| id_dev | output | 8 | Device code from the last ID request |
| id_lock | output | 1 | Boot lockout flag from the last ID request |
| fl_addr | output | AW | Flash address bus |
| fl_dout | output | DW | Flash write data |
| fl_din | input | DW | Flash read data |
| fl_ce_n | output | 1 | Flash chip enable, active low |
| fl_oe_n | output | 1 | Flash output enable, active low |
| fl_we_n | output | 1 | Flash write enable, active low |

## Verification
The bench models a flash device that flips bit 6 on each read for a chosen number of busy reads, then returns stable data.

- A busy count of zero shows that the block needs two agreeing reads and does not stop after the first.
- A busy count of three confirms the read count of busy-plus-one.
- A device that never settles exposes the program limit and the reset write.
- A sector erase that stays busy past the program limit, but within the erase limit, shows that the two limits are kept apart.
- The ID request is checked against distinct codes at addresses 0, 1 and 2, which catches swapped reads or wrong bit picks.

// File: rtl/flseq_pkg.sv
package flseq_pkg;

  typedef enum logic [1:0] {OP_PROG = 2'd0, OP_SECT = 2'd1, OP_CHIP = 2'd2, OP_ID = 2'd3} op_e;

  localparam logic [14:0] UNLOCK_A = 15'h5555;
  localparam logic [14:0] UNLOCK_B = 15'h2AAA;
  localparam logic [7:0]  CMD_RESET = 8'hF0;

  function automatic int unsigned umax(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

  // number of command writes for an operation
  function automatic logic [2:0] cmd_len(input op_e op);
    case (op)
      OP_PROG: return 3'd4;
      OP_ID:   return 3'd3;
      default: return 3'd6;
    endcase
  endfunction

  // unlock address alternates: slots 1 and 4 use the second unlock address
  function automatic logic [14:0] cmd_addr(input logic [2:0] idx);
    return (idx == 3'd1 || idx == 3'd4) ? UNLOCK_B : UNLOCK_A;
  endfunction

  function automatic logic [7:0] cmd_byte(input op_e op, input logic [2:0] idx);
    case (idx)
      3'd0, 3'd3: return 8'hAA;
      3'd1, 3'd4: return 8'h55;
      3'd2: begin
        case (op)
          OP_PROG: return 8'hA0;
          OP_ID:   return 8'h90;
          default: return 8'h80;
        endcase
      end
      default: return (op == OP_CHIP) ? 8'h10 : 8'h30;
    endcase
  endfunction

  // true when the slot goes to the caller's address instead of an unlock address
  function automatic logic cmd_on_target(input op_e op, input logic [2:0] idx);
    return (op == OP_PROG && idx == 3'd3) || (op == OP_SECT && idx == 3'd5);
  endfunction

  function automatic logic bit6_settled(input logic [15:0] prev, input logic [15:0] cur);
    return prev[6] == cur[6];
  endfunction

endpackage

// File: rtl/flseq_buscyc.sv
module flseq_buscyc #(
  parameter int AW    = 19,
  parameter int DW    = 16,
  parameter int T_AS  = 1,
  parameter int T_WP  = 5,
  parameter int T_WPH = 5,
  parameter int T_OEH = 8,
  parameter int T_OE  = 7
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          go,
  input  logic          go_rd,
  input  logic [AW-1:0] go_addr,
  input  logic [DW-1:0] go_data,
  output logic          fin,
  output logic [DW-1:0] rd_word,
  output logic [AW-1:0] fl_addr,
  output logic [DW-1:0] fl_dout,
  input  logic [DW-1:0] fl_din,
  output logic          fl_ce_n,
  output logic          fl_oe_n,
  output logic          fl_we_n
);
  import flseq_pkg::*;

  localparam int unsigned TMAX = umax(umax(umax(T_AS, T_WP), umax(T_WPH, T_OEH)), T_OE);
  localparam int CW = $clog2(TMAX + 1);

  typedef enum logic [2:0] {PH_IDLE, PH_SET, PH_LOW, PH_HIGH, PH_GAP, PH_OE} ph_e;

  ph_e           ph;
  logic [CW-1:0] cnt;
  logic          cnt_zero;

  assign cnt_zero = (cnt == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph      <= PH_IDLE;
      cnt     <= '0;
      fin     <= 1'b0;
      rd_word <= '0;
      fl_addr <= '0;
      fl_dout <= '0;
      fl_ce_n <= 1'b1;
      fl_oe_n <= 1'b1;
      fl_we_n <= 1'b1;
    end else begin
      fin <= 1'b0;
      case (ph)
        PH_IDLE: if (go) begin
          fl_addr <= go_addr;
          fl_dout <= go_data;
          fl_ce_n <= 1'b0;
          if (go_rd) begin
            ph  <= PH_GAP;
            cnt <= CW'(T_OEH - 1);
          end else begin
            ph  <= PH_SET;
            cnt <= CW'(T_AS - 1);
          end
        end
        PH_SET: if (cnt_zero) begin
          fl_we_n <= 1'b0;
          ph      <= PH_LOW;
          cnt     <= CW'(T_WP - 1);
        end else cnt <= cnt - 1'b1;
        PH_LOW: if (cnt_zero) begin
          fl_we_n <= 1'b1;
          ph      <= PH_HIGH;
          cnt     <= CW'(T_WPH - 1);
        end else cnt <= cnt - 1'b1;
        PH_HIGH: if (cnt_zero) begin
          fl_ce_n <= 1'b1;
          fin     <= 1'b1;
          ph      <= PH_IDLE;
        end else cnt <= cnt - 1'b1;
        PH_GAP: if (cnt_zero) begin
          fl_oe_n <= 1'b0;
          ph      <= PH_OE;
          cnt     <= CW'(T_OE - 1);
        end else cnt <= cnt - 1'b1;
        PH_OE: if (cnt_zero) begin
          rd_word <= fl_din;
          fl_oe_n <= 1'b1;
          fl_ce_n <= 1'b1;
          fin     <= 1'b1;
          ph      <= PH_IDLE;
        end else cnt <= cnt - 1'b1;
        default: ph <= PH_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/flseq_wdog.sv
module flseq_wdog #(
  parameter int TW = 29
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          run,
  input  logic [TW-1:0] limit,
  output logic          expired
);
  logic [TW-1:0] cnt;

  assign expired = (cnt >= limit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                cnt <= '0;
    else if (clr)              cnt <= '0;
    else if (run && !expired)  cnt <= cnt + 1'b1;
  end

endmodule

// File: rtl/flseq_top.sv
module flseq_top #(
  parameter int          AW       = 19,
  parameter int          DW       = 16,
  parameter int          T_AS     = 1,
  parameter int          T_WP     = 5,
  parameter int          T_WPH    = 5,
  parameter int          T_OEH    = 8,
  parameter int          T_OE     = 7,
  parameter int unsigned PROG_TO  = 2500,
  parameter int unsigned ERASE_TO = 500000000
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic [1:0]    req_op,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_data,
  output logic          done_valid,
  output logic          done_err,
  output logic [7:0]    id_mfr,
  output logic [7:0]    id_dev,
  output logic          id_lock,
  output logic [AW-1:0] fl_addr,
  output logic [DW-1:0] fl_dout,
  input  logic [DW-1:0] fl_din,
  output logic          fl_ce_n,
  output logic          fl_oe_n,
  output logic          fl_we_n
);
  import flseq_pkg::*;

  localparam int unsigned TO_MAX = umax(PROG_TO, ERASE_TO);
  localparam int TW = $clog2(TO_MAX + 1);

  typedef enum logic [3:0] {
    S_IDLE, S_CMD, S_CMDW, S_POLL, S_POLLW, S_IDRD, S_IDRDW, S_EXIT, S_EXITW, S_DONE
  } st_e;

  st_e           st;
  op_e           op_q;
  logic [AW-1:0] addr_q;
  logic [DW-1:0] data_q;
  logic [2:0]    idx_q;
  logic [DW-1:0] prev_q;
  logic          have_prev_q;
  logic          err_q;

  logic          bus_go, bus_rd, bus_fin;
  logic [AW-1:0] bus_addr;
  logic [DW-1:0] bus_wdata, bus_rword;

  // named events for the checker and for reading the FSM
  logic          accept;
  logic          last_cmd;
  logic          poll_settled;
  logic          wd_clr, wd_run, wd_expired;
  logic [TW-1:0] wd_limit;

  assign accept       = req_valid && req_ready;
  assign last_cmd     = (idx_q == cmd_len(op_q) - 3'd1);
  assign poll_settled = have_prev_q && bit6_settled(16'(prev_q), 16'(bus_rword));
  assign wd_clr       = (st == S_CMDW) && bus_fin && last_cmd && (op_q != OP_ID);
  assign wd_run       = (st == S_POLL) || (st == S_POLLW);
  assign wd_limit     = (op_q == OP_PROG) ? TW'(PROG_TO) : TW'(ERASE_TO);

  assign req_ready  = (st == S_IDLE);
  assign done_valid = (st == S_DONE);
  assign done_err   = err_q;

  always_comb begin
    bus_go    = 1'b0;
    bus_rd    = 1'b0;
    bus_addr  = addr_q;
    bus_wdata = data_q;
    case (st)
      S_CMD: begin
        bus_go = 1'b1;
        if (!cmd_on_target(op_q, idx_q)) begin
          bus_addr = AW'(cmd_addr(idx_q));
          bus_wdata = DW'(cmd_byte(op_q, idx_q));
        end else if (op_q == OP_SECT) begin
          bus_wdata = DW'(cmd_byte(op_q, idx_q));
        end
      end
      S_POLL: begin
        bus_go = 1'b1;
        bus_rd = 1'b1;
      end
      S_IDRD: begin
        bus_go   = 1'b1;
        bus_rd   = 1'b1;
        bus_addr = AW'(idx_q);
      end
      S_EXIT: begin
        bus_go    = 1'b1;
        bus_addr  = AW'(UNLOCK_A);
        bus_wdata = DW'(CMD_RESET);
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st          <= S_IDLE;
      op_q        <= OP_PROG;
      addr_q      <= '0;
      data_q      <= '0;
      idx_q       <= '0;
      prev_q      <= '0;
      have_prev_q <= 1'b0;
      err_q       <= 1'b0;
      id_mfr      <= '0;
      id_dev      <= '0;
      id_lock     <= 1'b0;
    end else begin
      case (st)
        S_IDLE: if (accept) begin
          op_q   <= op_e'(req_op);
          addr_q <= req_addr;
          data_q <= req_data;
          idx_q  <= '0;
          err_q  <= 1'b0;
          st     <= S_CMD;
        end
        S_CMD: st <= S_CMDW;
        S_CMDW: if (bus_fin) begin
          if (!last_cmd) begin
            idx_q <= idx_q + 3'd1;
            st    <= S_CMD;
          end else if (op_q == OP_ID) begin
            idx_q <= '0;
            st    <= S_IDRD;
          end else begin
            have_prev_q <= 1'b0;
            st          <= S_POLL;
          end
        end
        S_POLL: st <= S_POLLW;
        S_POLLW: if (bus_fin) begin
          if (poll_settled) begin
            st <= S_DONE;
          end else if (wd_expired) begin
            err_q <= 1'b1;
            st    <= S_EXIT;
          end else begin
            have_prev_q <= 1'b1;
            prev_q      <= bus_rword;
            st          <= S_POLL;
          end
        end
        S_IDRD: st <= S_IDRDW;
        S_IDRDW: if (bus_fin) begin
          case (idx_q)
            3'd0:    id_mfr  <= bus_rword[7:0];
            3'd1:    id_dev  <= bus_rword[7:0];
            default: id_lock <= bus_rword[0];
          endcase
          if (idx_q == 3'd2) st <= S_EXIT;
          else begin
            idx_q <= idx_q + 3'd1;
            st    <= S_IDRD;
          end
        end
        S_EXIT:  st <= S_EXITW;
        S_EXITW: if (bus_fin) st <= S_DONE;
        S_DONE:  st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end

  flseq_buscyc #(
    .AW(AW), .DW(DW), .T_AS(T_AS), .T_WP(T_WP), .T_WPH(T_WPH), .T_OEH(T_OEH), .T_OE(T_OE)
  ) u_bus (
    .clk(clk), .rst_n(rst_n),
    .go(bus_go), .go_rd(bus_rd), .go_addr(bus_addr), .go_data(bus_wdata),
    .fin(bus_fin), .rd_word(bus_rword),
    .fl_addr(fl_addr), .fl_dout(fl_dout), .fl_din(fl_din),
    .fl_ce_n(fl_ce_n), .fl_oe_n(fl_oe_n), .fl_we_n(fl_we_n)
  );

  flseq_wdog #(.TW(TW)) u_wdog (
    .clk(clk), .rst_n(rst_n), .clr(wd_clr), .run(wd_run),
    .limit(wd_limit), .expired(wd_expired)
  );

endmodule

// File: rtl/flseq_chk.sv
module flseq_chk #(
  parameter int AW    = 19,
  parameter int DW    = 16,
  parameter int T_WP  = 5,
  parameter int T_WPH = 5,
  parameter int T_OEH = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          req_valid,
  input logic          req_ready,
  input logic          done_valid,
  input logic [AW-1:0] fl_addr,
  input logic [DW-1:0] fl_dout,
  input logic          fl_ce_n,
  input logic          fl_oe_n,
  input logic          fl_we_n
);
  logic [15:0] we_lo_cnt, we_hi_cnt, oe_hi_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      we_lo_cnt <= '0;
      we_hi_cnt <= 16'(T_WPH);
      oe_hi_cnt <= 16'(T_OEH);
    end else begin
      we_lo_cnt <= !fl_we_n ? ((we_lo_cnt == 16'hFFFF) ? we_lo_cnt : we_lo_cnt + 1'b1) : '0;
      we_hi_cnt <=  fl_we_n ? ((we_hi_cnt == 16'hFFFF) ? we_hi_cnt : we_hi_cnt + 1'b1) : '0;
      oe_hi_cnt <=  fl_oe_n ? ((oe_hi_cnt == 16'hFFFF) ? oe_hi_cnt : oe_hi_cnt + 1'b1) : '0;
    end
  end

  p_ack_drops_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready);

  p_we_width_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fl_we_n) |-> (we_lo_cnt >= 16'(T_WP)));

  p_we_gap_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(fl_we_n) |-> (we_hi_cnt >= 16'(T_WPH)));

  p_wr_stable_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!fl_we_n && $past(!fl_we_n)) |-> ($stable(fl_addr) && $stable(fl_dout)));

  p_oe_we_excl_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !fl_we_n |-> fl_oe_n);

  p_we_needs_ce_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !fl_we_n |-> !fl_ce_n);

  p_oe_gap_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(fl_oe_n) |-> (oe_hi_cnt >= 16'(T_OEH)));

  p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done_valid |=> !done_valid);

endmodule

bind flseq_top flseq_chk #(
  .AW(AW), .DW(DW), .T_WP(T_WP), .T_WPH(T_WPH), .T_OEH(T_OEH)
) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .done_valid(done_valid), .fl_addr(fl_addr), .fl_dout(fl_dout),
  .fl_ce_n(fl_ce_n), .fl_oe_n(fl_oe_n), .fl_we_n(fl_we_n)
);

// File: tb/flseq_top_tb.sv
`timescale 1ns/1ps
module flseq_top_tb;
  localparam int AW = 19;
  localparam int DW = 16;
  localparam int T_WP = 5;
  localparam int T_OEH = 8;
  localparam int PROG_TO = 300;
  localparam int ERASE_TO = 900;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0;
  logic req_ready;
  logic [1:0] req_op = '0;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_data = '0;
  logic done_valid, done_err, id_lock;
  logic [7:0] id_mfr, id_dev;
  logic [AW-1:0] fl_addr;
  logic [DW-1:0] fl_dout, fl_din;
  logic fl_ce_n, fl_oe_n, fl_we_n;

  always #10 clk = ~clk;

  flseq_top #(.AW(AW), .DW(DW), .T_WP(T_WP), .T_OEH(T_OEH),
              .PROG_TO(PROG_TO), .ERASE_TO(ERASE_TO)) u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_op(req_op), .req_addr(req_addr), .req_data(req_data),
    .done_valid(done_valid), .done_err(done_err),
    .id_mfr(id_mfr), .id_dev(id_dev), .id_lock(id_lock),
    .fl_addr(fl_addr), .fl_dout(fl_dout), .fl_din(fl_din),
    .fl_ce_n(fl_ce_n), .fl_oe_n(fl_oe_n), .fl_we_n(fl_we_n));

  int checks = 0;
  int errors = 0;
  int cyc = 0;

  // device model and bus logs
  logic [AW-1:0] wr_addr [64];
  logic [DW-1:0] wr_data [64];
  logic [AW-1:0] rd_addr [64];
  int wr_n = 0, rd_n = 0;
  int busy_cfg = 0, busy = 0;
  logic tog = 1'b0, id_mode = 1'b0;
  logic [7:0] prev_byte = 8'h00;
  int last_wr_cyc = 0;

  always @(posedge fl_we_n) if (rst_n) begin
    if (wr_n < 64) begin wr_addr[wr_n] = fl_addr; wr_data[wr_n] = fl_dout; end
    wr_n = wr_n + 1;
    last_wr_cyc = cyc;
    if (prev_byte == 8'hA0) busy = busy_cfg;
    else if ((fl_dout[7:0] == 8'h30 || fl_dout[7:0] == 8'h10) && prev_byte == 8'h55) busy = busy_cfg;
    else if (fl_dout[7:0] == 8'h90 && prev_byte == 8'h55) id_mode = 1'b1;
    else if (fl_dout[7:0] == 8'hF0) begin id_mode = 1'b0; busy = 0; end
    prev_byte = fl_dout[7:0];
  end

  always @(negedge fl_oe_n) if (rst_n) begin
    if (rd_n < 64) rd_addr[rd_n] = fl_addr;
    rd_n = rd_n + 1;
    if (busy != 0) begin
      tog = ~tog;
      if (busy > 0) busy = busy - 1;
    end
  end

  always_comb begin
    if (id_mode) begin
      case (fl_addr)
        19'd0:   fl_din = 16'h001F;
        19'd1:   fl_din = 16'h00A3;
        19'd2:   fl_din = 16'h0001;
        default: fl_din = 16'h0000;
      endcase
    end else fl_din = 16'h1200 | {9'd0, tog, 6'd0};
  end

  // bus timing monitors
  int we_lo = 0, min_we_lo = 1000, oe_hi = 0, min_oe_hi = 1000, overlap = 0;
  logic oe_seen = 1'b0;
  always @(posedge clk) begin
    cyc = cyc + 1;
    if (rst_n) begin
      if (!fl_we_n) we_lo = we_lo + 1;
      else if (we_lo > 0) begin
        if (we_lo < min_we_lo) min_we_lo = we_lo;
        we_lo = 0;
      end
      if (fl_oe_n) oe_hi = oe_hi + 1;
      else begin
        if (oe_seen && oe_hi > 0 && oe_hi < min_oe_hi) min_oe_hi = oe_hi;
        if (oe_hi > 0) oe_seen = 1'b1;
        oe_hi = 0;
      end
      if (!fl_we_n && !fl_oe_n) overlap = overlap + 1;
      if (!fl_we_n && fl_ce_n) overlap = overlap + 1;
    end
    if (cyc > 190000) begin
      errors = errors + 1;
      $display("FAIL watchdog: run hung, actual cycle %0d expected < 190000", cyc);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic chk(input logic ok, input string tag, input longint act, input longint exp);
    checks = checks + 1;
    if (!ok) begin
      errors = errors + 1;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic issue(input logic [1:0] op, input logic [AW-1:0] a, input logic [DW-1:0] d, input int bz);
    @(negedge clk);
    wr_n = 0; rd_n = 0; busy_cfg = bz;
    req_valid = 1'b1; req_op = op; req_addr = a; req_data = d;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    chk(req_ready == 1'b0, "R1 ready drops after accept", req_ready, 0);
  endtask

  task automatic wait_done(output logic err, output int done_cyc);
    int n = 0;
    while (!done_valid && n < 20000) begin @(negedge clk); n++; end
    chk(done_valid == 1'b1, "R10 done seen", done_valid, 1);
    err = done_err; done_cyc = cyc;
    @(negedge clk);
    chk(done_valid == 1'b0, "R10 done one cycle", done_valid, 0);
    chk(req_ready == 1'b1, "R1 ready after done", req_ready, 1);
  endtask

  task automatic chk_wr(input int i, input logic [AW-1:0] a, input logic [DW-1:0] d, input string tag);
    chk(wr_addr[i] == a, tag, wr_addr[i], a);
    chk(wr_data[i] == d, tag, wr_data[i], d);
  endtask

  task automatic t_reset;
    chk(fl_ce_n && fl_oe_n && fl_we_n, "R11 strobes high", {fl_ce_n, fl_oe_n, fl_we_n}, 3'b111);
    chk(req_ready == 1'b1, "R11 ready", req_ready, 1);
    chk(done_valid == 1'b0, "R11 done low", done_valid, 0);
  endtask

  task automatic t_program(input logic [AW-1:0] a, input logic [DW-1:0] d, input int bz);
    logic e; int dc;
    int exp_rd = (bz + 1 > 2) ? bz + 1 : 2;
    issue(2'd0, a, d, bz);
    wait_done(e, dc);
    chk(wr_n == 4, "R2 program write count", wr_n, 4);
    chk_wr(0, 19'h05555, 16'h00AA, "R2 write 1");
    chk_wr(1, 19'h02AAA, 16'h0055, "R2 write 2");
    chk_wr(2, 19'h05555, 16'h00A0, "R2 write 3");
    chk_wr(3, a, d, "R2 write 4");
    chk(rd_n == exp_rd, "R7 poll read count", rd_n, exp_rd);
    for (int i = 0; i < rd_n && i < 64; i++)
      chk(rd_addr[i] == a, "R7 poll address", rd_addr[i], a);
    chk(e == 1'b0, "R8 settled no error", e, 0);
  endtask

  task automatic t_erase(input logic chip, input logic [AW-1:0] a, input int bz);
    logic e; int dc;
    issue(chip ? 2'd2 : 2'd1, a, 16'hFFFF, bz);
    wait_done(e, dc);
    chk(wr_n == 6, chip ? "R4 write count" : "R3 write count", wr_n, 6);
    chk_wr(0, 19'h05555, 16'h00AA, "R3 unlock 1");
    chk_wr(1, 19'h02AAA, 16'h0055, "R3 unlock 2");
    chk_wr(2, 19'h05555, 16'h0080, "R3 erase setup");
    chk_wr(3, 19'h05555, 16'h00AA, "R3 unlock 3");
    chk_wr(4, 19'h02AAA, 16'h0055, "R3 unlock 4");
    if (chip) chk_wr(5, 19'h05555, 16'h0010, "R4 chip command");
    else      chk_wr(5, a, 16'h0030, "R3 sector command");
    chk(rd_n == bz + 1, "R7 erase poll count", rd_n, bz + 1);
    chk(e == 1'b0, "R8 erase uses erase limit", e, 0);
  endtask

  task automatic t_timeout;
    logic e; int dc; int start;
    issue(2'd0, 19'h00100, 16'h5A5A, -1);
    wait_done(e, dc);
    chk(e == 1'b1, "R8 timeout error", e, 1);
    chk(wr_n == 5, "R8 reset write issued", wr_n, 5);
    chk_wr(4, 19'h05555, 16'h00F0, "R8 reset write");
    start = 0;
    // fourth write ended at least PROG_TO before the done pulse
    chk(rd_n * (T_OEH + 9) >= PROG_TO, "R8 waited program limit", rd_n, PROG_TO / (T_OEH + 9));
    chk(rd_n * (T_OEH + 7) <= PROG_TO + 60, "R8 stopped near limit", rd_n, PROG_TO / (T_OEH + 7));
  endtask

  task automatic t_id;
    logic e; int dc;
    issue(2'd3, 19'h12345, 16'h0000, 0);
    wait_done(e, dc);
    chk(wr_n == 4, "R9 write count", wr_n, 4);
    chk_wr(0, 19'h05555, 16'h00AA, "R9 entry 1");
    chk_wr(1, 19'h02AAA, 16'h0055, "R9 entry 2");
    chk_wr(2, 19'h05555, 16'h0090, "R9 entry 3");
    chk_wr(3, 19'h05555, 16'h00F0, "R9 exit");
    chk(rd_n == 3, "R9 read count", rd_n, 3);
    for (int i = 0; i < 3; i++) chk(rd_addr[i] == AW'(i), "R9 read address", rd_addr[i], i);
    chk(id_mfr == 8'h1F, "R9 manufacturer", id_mfr, 8'h1F);
    chk(id_dev == 8'hA3, "R9 device", id_dev, 8'hA3);
    chk(id_lock == 1'b1, "R9 lock flag", id_lock, 1);
    chk(e == 1'b0, "R9 no error", e, 0);
  endtask

  task automatic t_timing;
    chk(min_we_lo >= T_WP, "R5 write pulse width", min_we_lo, T_WP);
    chk(min_oe_hi >= T_OEH, "R7 read gap", min_oe_hi, T_OEH);
    chk(overlap == 0, "R6 strobe overlap", overlap, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_program(19'h01234, 16'hBEEF, 3);
    t_program(19'h7FFFE, 16'h0001, 0);
    t_erase(1'b0, 19'h05123, 20);
    t_erase(1'b1, 19'h00000, 2);
    t_timeout();
    t_id();
    t_timing();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule